// File: doc/BRIEF.md
# Queue Status and Interrupt Aggregator

This block collects the condition flags of 64 hardware queues into packed, word-readable status registers. It also drives a single interrupt line toward a host processor. The queue datapath lies outside the block. Flags arrive as flat input vectors, and underflow and overflow arrive as single-cycle event pulses.

Queues are split into two unequal groups:

- **Lower group (queues 0 to 31).** Each queue has a four-bit status nibble. Each queue also has its own programmable interrupt condition, chosen from any flag or its inverse.
- **Upper group (queues 32 to 63).** Each queue reports only nearly-empty and full, as one bit each in two separate words. Its interrupt condition is always nearly-empty.

A host reads and writes words through a simple port. The address selects a word, writes take effect at the clock edge, and read data appears one cycle after the address. Interrupt status bits are sticky and cleared by writing ones. The interrupt line is the OR of every status bit that is both set and enabled. Nibble bit 3 of queue 0's selector is not a selector bit: it is a separate control bit, brought out on its own pin and written only through its own address.

Top module: `qstat_irq_unit`

Word map (word addresses):

| Address | Contents |
|---|---|
| 0–3 | Lower status |
| 4–5 | Underflow/overflow |
| 6 | Upper nearly-empty |
| 7 | Upper full |
| 8–11 | Source selectors |
| 12–13 | Interrupt enable |
| 14–15 | Interrupt status |
| 16 | Control bit |
| 17–31 | Unmapped |

## Requirements
- R1: While `rst` is high and on the first read after it, the registers hold their reset values: lower status words 0x33333333, underflow/overflow 0, upper nearly-empty 0xFFFFFFFF, upper full 0, selectors 0, enables 0, interrupt status 0xFFFFFFFF, and `irq` low.
- R2: Lower status word 0–3 holds queue q in word q/8, nibble q%8 (bits 4*(q%8)+3:4*(q%8)). Within the nibble, bit 0 is empty, bit 1 nearly-empty, bit 2 nearly-full and bit 3 full. Flags are captured at the next clock edge, and `rdata` shows the addressed word one cycle after `addr`.
- R3: Word 6 holds upper nearly-empty and word 7 holds upper full, with bit j carrying queue 32+j.
- R4: Words 4–5 hold two bits per lower queue, at word 4+q/16, bits 2*(q%16)+1:2*(q%16). The low bit records underflow and the high bit overflow. A pulse sets its bit at the next edge, and the bit stays set until written with a one. A new pulse wins over a same-cycle clear.
- R5: Selector words 8–11 use the same nibble placement as R2. Selector bits 1:0 pick empty (0), nearly-empty (1), nearly-full (2) or full (3), and bit 2 inverts the picked flag.
- R6: The interrupt condition of upper queue 32+j is its nearly-empty input, regardless of any selector.
- R7: Interrupt status word 14 covers queues 0–31 and word 15 covers queues 32–63, bit = queue index mod 32. A bit sets at the edge after its condition is true at the inputs, and it is cleared by writing one. A true condition wins over a same-cycle clear, and no other write clears a bit.
- R8: Interrupt enable words 12 (queues 0–31) and 13 (queues 32–63) gate the status bits. `irq` is registered and equals the OR of all set and enabled status bits, so it rises at the same edge that sets a qualifying status bit, one cycle after the flag input.
- R9: A write to selector word 8 changes only bits 2:0 of queue 0's nibble. Bit 3 of that nibble is the control bit: it is written from `wdata[0]` at address 16, read back at word 8 bit 3 and at word 16 bit 0, and drives `aux_ctrl`. Bit 3 of every other selector nibble reads 0.
- R10: Reads of unmapped addresses 17–31 return 0. Writes to the read-only status words 0–3, 6 and 7, and to unmapped addresses, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_empty | input | 32 | Empty flag of queues 0–31 |
| lo_nempty | input | 32 | Nearly-empty flag of queues 0–31 |
| lo_nfull | input | 32 | Nearly-full flag of queues 0–31 |
| lo_full | input | 32 | Full flag of queues 0–31 |
| up_nempty | input | 32 | Nearly-empty flag of queues 32–63 |
| up_full | input | 32 | Full flag of queues 32–63 |
| lo_uflow | input | 32 | Underflow event pulse, queues 0–31 |
| lo_oflow | input | 32 | Overflow event pulse, queues 0–31 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| aux_ctrl | output | 1 | Separate control bit stored in queue 0's selector nibble |

## Verification
The bench uses the default sizes: 32 lower queues, 32 upper queues and a 32-bit word. At these sizes every field of every word is an ordinary bit that random writes and random flag vectors reach. That covers:

- queue 0's protected nibble bit;
- the word boundary between the two underflow/overflow words;
- the lower/upper split inside the enable and status pairs.

A behavioural model tracks every register and compares `rdata` and `irq` each cycle. Directed sequences pin the cases random traffic hits only by chance: a set condition beating a clear, an inverted selector, the fixed upper source, and a full-word selector write that must not disturb the control bit.

// File: rtl/qsi_pkg.sv
package qsi_pkg;

  // Flag order inside a lower-group status nibble; also the selector code.
  typedef enum logic [1:0] {
    SRC_EMPTY  = 2'd0,
    SRC_NEMPTY = 2'd1,
    SRC_NFULL  = 2'd2,
    SRC_FULL   = 2'd3
  } src_flag_e;

  localparam int NIB_W = 4;   // status / selector bits per lower queue
  localparam int UO_W  = 2;   // underflow/overflow bits per lower queue

  // Interrupt condition of one lower queue: picked flag, optionally inverted.
  function automatic logic src_hit(input logic [3:0] nib, input logic [2:0] sel);
    logic picked;
    case (src_flag_e'(sel[1:0]))
      SRC_EMPTY:  picked = nib[0];
      SRC_NEMPTY: picked = nib[1];
      SRC_NFULL:  picked = nib[2];
      default:    picked = nib[3];
    endcase
    return picked ^ sel[2];
  endfunction

endpackage

// File: rtl/qsi_capture.sv
module qsi_capture #(
  parameter int NLO = 32,
  parameter int NUP = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [qsi_pkg::NIB_W*NLO-1:0] lo_nib_in,
  input  logic [NUP-1:0]                up_ne_in,
  input  logic [NUP-1:0]                up_f_in,
  input  logic [NLO-1:0]                uflow,
  input  logic [NLO-1:0]                oflow,
  input  logic [qsi_pkg::UO_W*NLO-1:0]  uo_clr,
  output logic [qsi_pkg::NIB_W*NLO-1:0] lo_stat,
  output logic [NUP-1:0]                up_ne,
  output logic [NUP-1:0]                up_f,
  output logic [qsi_pkg::UO_W*NLO-1:0]  uo_stat
);
  import qsi_pkg::*;

  // Flag snapshot; reset shows every lower queue as empty and nearly-empty.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < NLO; q++) lo_stat[NIB_W*q +: NIB_W] <= 4'b0011;
      up_ne <= '1;
      up_f  <= '0;
    end else begin
      lo_stat <= lo_nib_in;
      up_ne   <= up_ne_in;
      up_f    <= up_f_in;
    end
  end

  // Sticky event bits, cleared by write-one; a fresh event wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      uo_stat <= '0;
    end else begin
      for (int q = 0; q < NLO; q++) begin
        uo_stat[UO_W*q]     <= (uo_stat[UO_W*q]     & ~uo_clr[UO_W*q])     | uflow[q];
        uo_stat[UO_W*q + 1] <= (uo_stat[UO_W*q + 1] & ~uo_clr[UO_W*q + 1]) | oflow[q];
      end
    end
  end

endmodule

// File: rtl/qsi_irq_ctrl.sv
module qsi_irq_ctrl #(
  parameter int NLO = 32,
  parameter int NUP = 32,
  parameter int DW  = 32,
  localparam int NQ        = NLO + NUP,
  localparam int QPW       = DW / qsi_pkg::NIB_W,
  localparam int SEL_WORDS = qsi_pkg::NIB_W * NLO / DW,
  localparam int IQ_WORDS  = NQ / DW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [qsi_pkg::NIB_W*NLO-1:0] lo_nib_in,
  input  logic [NUP-1:0]                up_ne_in,
  input  logic [SEL_WORDS-1:0]          sel_we,
  input  logic                          aux_we,
  input  logic [IQ_WORDS-1:0]           ien_we,
  input  logic [NQ-1:0]                 ist_clr,
  input  logic [DW-1:0]                 wdata,
  output logic [qsi_pkg::NIB_W*NLO-1:0] sel_q,
  output logic [NQ-1:0]                 ien_q,
  output logic [NQ-1:0]                 ist_q,
  output logic                          irq
);
  import qsi_pkg::*;

  logic [NQ-1:0]          cond;
  logic [NQ-1:0]          ist_d;
  logic [NQ-1:0]          ien_d;
  logic [NIB_W*NLO-1:0]   sel_d;

  // Interrupt condition per queue: programmable below, fixed above.
  always_comb begin
    for (int q = 0; q < NLO; q++)
      cond[q] = src_hit(lo_nib_in[NIB_W*q +: NIB_W], sel_q[NIB_W*q +: 3]);
    for (int j = 0; j < NUP; j++)
      cond[NLO + j] = up_ne_in[j];
  end

  always_comb begin
    ist_d = (ist_q & ~ist_clr) | cond;
    ien_d = ien_q;
    for (int w = 0; w < IQ_WORDS; w++)
      if (ien_we[w]) ien_d[w*DW +: DW] = wdata;
  end

  // Word writes touch selector bits 2:0 only; queue 0 bit 3 has its own strobe.
  always_comb begin
    sel_d = sel_q;
    for (int w = 0; w < SEL_WORDS; w++) begin
      if (sel_we[w]) begin
        for (int k = 0; k < QPW; k++) begin
          sel_d[NIB_W*(w*QPW + k) +: 3] = wdata[NIB_W*k +: 3];
        end
      end
    end
    if (aux_we) sel_d[3] = wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      ien_q <= '0;
      ist_q <= '1;
      irq   <= 1'b0;
    end else begin
      sel_q <= sel_d;
      ien_q <= ien_d;
      ist_q <= ist_d;
      irq   <= |(ist_d & ien_d);
    end
  end

endmodule

// File: rtl/qstat_irq_unit.sv
module qstat_irq_unit #(
  parameter int NLO = 32,
  parameter int NUP = 32,
  parameter int DW  = 32,
  parameter int AW  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NLO-1:0] lo_empty,
  input  logic [NLO-1:0] lo_nempty,
  input  logic [NLO-1:0] lo_nfull,
  input  logic [NLO-1:0] lo_full,
  input  logic [NUP-1:0] up_nempty,
  input  logic [NUP-1:0] up_full,
  input  logic [NLO-1:0] lo_uflow,
  input  logic [NLO-1:0] lo_oflow,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq,
  output logic           aux_ctrl
);
  import qsi_pkg::*;

  localparam int NQ       = NLO + NUP;
  localparam int LS_WORDS = NIB_W * NLO / DW;
  localparam int UO_WORDS = UO_W * NLO / DW;
  localparam int IQ_WORDS = NQ / DW;
  localparam int A_LS     = 0;
  localparam int A_UO     = A_LS + LS_WORDS;
  localparam int A_UPNE   = A_UO + UO_WORDS;
  localparam int A_UPF    = A_UPNE + 1;
  localparam int A_SEL    = A_UPF + 1;
  localparam int A_IEN    = A_SEL + LS_WORDS;
  localparam int A_IST    = A_IEN + IQ_WORDS;
  localparam int A_AUX    = A_IST + IQ_WORDS;

  logic [NIB_W*NLO-1:0] lo_nib;
  logic [NIB_W*NLO-1:0] lo_stat_q;
  logic [NIB_W*NLO-1:0] sel_q;
  logic [UO_W*NLO-1:0]  uo_q;
  logic [UO_W*NLO-1:0]  uo_clr;
  logic [NUP-1:0]       up_ne_q;
  logic [NUP-1:0]       up_f_q;
  logic [NQ-1:0]        ien_q;
  logic [NQ-1:0]        ist_q;
  logic [NQ-1:0]        ist_clr;
  logic [LS_WORDS-1:0]  sel_we;
  logic [IQ_WORDS-1:0]  ien_we;
  logic                 aux_we;
  logic [DW-1:0]        rd_d;

  always_comb begin
    for (int q = 0; q < NLO; q++)
      lo_nib[NIB_W*q +: NIB_W] = {lo_full[q], lo_nfull[q], lo_nempty[q], lo_empty[q]};
  end

  // Write decode
  always_comb begin
    uo_clr  = '0;
    ist_clr = '0;
    sel_we  = '0;
    ien_we  = '0;
    aux_we  = 1'b0;
    if (wr_en) begin
      for (int w = 0; w < UO_WORDS; w++)
        if (addr == AW'(A_UO + w)) uo_clr[w*DW +: DW] = wdata;
      for (int w = 0; w < LS_WORDS; w++)
        if (addr == AW'(A_SEL + w)) sel_we[w] = 1'b1;
      for (int w = 0; w < IQ_WORDS; w++) begin
        if (addr == AW'(A_IEN + w)) ien_we[w] = 1'b1;
        if (addr == AW'(A_IST + w)) ist_clr[w*DW +: DW] = wdata;
      end
      if (addr == AW'(A_AUX)) aux_we = 1'b1;
    end
  end

  qsi_capture #(.NLO(NLO), .NUP(NUP)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .lo_nib_in (lo_nib),
    .up_ne_in  (up_nempty),
    .up_f_in   (up_full),
    .uflow     (lo_uflow),
    .oflow     (lo_oflow),
    .uo_clr    (uo_clr),
    .lo_stat   (lo_stat_q),
    .up_ne     (up_ne_q),
    .up_f      (up_f_q),
    .uo_stat   (uo_q)
  );

  qsi_irq_ctrl #(.NLO(NLO), .NUP(NUP), .DW(DW)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .lo_nib_in (lo_nib),
    .up_ne_in  (up_nempty),
    .sel_we    (sel_we),
    .aux_we    (aux_we),
    .ien_we    (ien_we),
    .ist_clr   (ist_clr),
    .wdata     (wdata),
    .sel_q     (sel_q),
    .ien_q     (ien_q),
    .ist_q     (ist_q),
    .irq       (irq)
  );

  assign aux_ctrl = sel_q[3];

  // Read mux; unmapped addresses return zero
  always_comb begin
    rd_d = '0;
    for (int w = 0; w < LS_WORDS; w++) begin
      if (addr == AW'(A_LS + w))  rd_d = lo_stat_q[w*DW +: DW];
      if (addr == AW'(A_SEL + w)) rd_d = sel_q[w*DW +: DW];
    end
    for (int w = 0; w < UO_WORDS; w++)
      if (addr == AW'(A_UO + w)) rd_d = uo_q[w*DW +: DW];
    if (addr == AW'(A_UPNE)) rd_d[NUP-1:0] = up_ne_q;
    if (addr == AW'(A_UPF))  rd_d[NUP-1:0] = up_f_q;
    for (int w = 0; w < IQ_WORDS; w++) begin
      if (addr == AW'(A_IEN + w)) rd_d = ien_q[w*DW +: DW];
      if (addr == AW'(A_IST + w)) rd_d = ist_q[w*DW +: DW];
    end
    if (addr == AW'(A_AUX)) rd_d[0] = sel_q[3];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

endmodule

// File: rtl/qstat_irq_unit_chk.sv
module qstat_irq_unit_chk #(
  parameter int NLO   = 32,
  parameter int NUP   = 32,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int A_SEL = 8,
  parameter int A_IST = 14,
  parameter int A_AUX = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [AW-1:0]      addr,
  input logic [DW-1:0]      wdata,
  input logic [NUP-1:0]     up_nempty,
  input logic [NLO-1:0]     lo_uflow,
  input logic [NLO-1:0]     lo_oflow,
  input logic [NLO+NUP-1:0] ist_q,
  input logic [NLO+NUP-1:0] ien_q,
  input logic [2*NLO-1:0]   uo_q,
  input logic [NUP-1:0]     up_ne_q,
  input logic               irq,
  input logic               aux_ctrl
);
  localparam int NQ = NLO + NUP;

  logic [2*NLO-1:0] ev;
  logic             ist_wr;

  always_comb begin
    for (int q = 0; q < NLO; q++) begin
      ev[2*q]     = lo_uflow[q];
      ev[2*q + 1] = lo_oflow[q];
    end
    ist_wr = 1'b0;
    for (int w = 0; w < NQ / DW; w++)
      if (wr_en && addr == AW'(A_IST + w)) ist_wr = 1'b1;
  end

  a_r3_up_ne_capture: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (up_ne_q == $past(up_nempty)));

  a_r4_event_sticks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((uo_q & $past(ev)) == $past(ev)));

  a_r6_upper_source: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ist_q[NQ-1:NLO] & $past(up_nempty)) == $past(up_nempty)));

  a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (rst)
    !ist_wr |=> ((ist_q & $past(ist_q)) == $past(ist_q)));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|(ist_q & ien_q)));

  a_r8_irq_no_enable: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |-> !irq);

  a_r9_aux_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(A_SEL)) |=> (aux_ctrl == $past(aux_ctrl)));

  a_r9_aux_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(A_AUX)) |=> (aux_ctrl == $past(wdata[0])));

endmodule

bind qstat_irq_unit qstat_irq_unit_chk #(
  .NLO(NLO), .NUP(NUP), .DW(DW), .AW(AW),
  .A_SEL(A_SEL), .A_IST(A_IST), .A_AUX(A_AUX)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .up_nempty (up_nempty),
  .lo_uflow  (lo_uflow),
  .lo_oflow  (lo_oflow),
  .ist_q     (ist_q),
  .ien_q     (ien_q),
  .uo_q      (uo_q),
  .up_ne_q   (up_ne_q),
  .irq       (irq),
  .aux_ctrl  (aux_ctrl)
);

// File: tb/qstat_irq_unit_tb.sv
module qstat_irq_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lo_empty = '0, lo_nempty = '0, lo_nfull = '0, lo_full = '0;
  logic [31:0] up_nempty = '0, up_full = '0, lo_uflow = '0, lo_oflow = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, aux_ctrl;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qstat_irq_unit u_dut (
    .clk(clk), .rst(rst),
    .lo_empty(lo_empty), .lo_nempty(lo_nempty), .lo_nfull(lo_nfull), .lo_full(lo_full),
    .up_nempty(up_nempty), .up_full(up_full),
    .lo_uflow(lo_uflow), .lo_oflow(lo_oflow),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .aux_ctrl(aux_ctrl)
  );

  // ---------------- behavioural reference model ----------------
  logic [3:0]  m_ls  [32];
  logic [2:0]  m_sel [32];
  logic        m_aux;
  logic [31:0] m_upne, m_upf;
  logic [63:0] m_uo, m_ien, m_ist;
  logic [31:0] m_rd;
  logic [4:0]  m_ra;
  logic        m_irq;

  function automatic logic [31:0] mread(input logic [4:0] a);
    logic [31:0] r = '0;
    if (a < 4) begin
      for (int k = 0; k < 8; k++) r[4*k +: 4] = m_ls[a*8 + k];
    end else if (a == 4) r = m_uo[31:0];
    else if (a == 5) r = m_uo[63:32];
    else if (a == 6) r = m_upne;
    else if (a == 7) r = m_upf;
    else if (a >= 8 && a < 12) begin
      for (int k = 0; k < 8; k++) r[4*k +: 4] = {1'b0, m_sel[(a-8)*8 + k]};
      if (a == 8) r[3] = m_aux;
    end
    else if (a == 12) r = m_ien[31:0];
    else if (a == 13) r = m_ien[63:32];
    else if (a == 14) r = m_ist[31:0];
    else if (a == 15) r = m_ist[63:32];
    else if (a == 16) r = {31'd0, m_aux};
    return r;
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    if (a < 4)  return "R2";
    if (a < 6)  return "R4";
    if (a < 8)  return "R3";
    if (a < 12) return "R5";
    if (a < 14) return "R8";
    if (a < 16) return "R7";
    if (a == 16) return "R9";
    return "R10";
  endfunction

  always @(posedge clk) begin
    logic [63:0] cond, iclr;
    logic [3:0]  nib;
    if (rst) begin
      for (int q = 0; q < 32; q++) begin m_ls[q] = 4'h3; m_sel[q] = '0; end
      m_aux = 0; m_upne = '1; m_upf = '0; m_uo = '0; m_ien = '0; m_ist = '1;
      m_rd = '0; m_irq = 0; m_ra = addr;
    end else begin
      m_rd = mread(addr);
      m_ra = addr;
      for (int q = 0; q < 32; q++) begin
        nib = {lo_full[q], lo_nfull[q], lo_nempty[q], lo_empty[q]};
        cond[q] = nib[m_sel[q][1:0]] ^ m_sel[q][2];
        cond[32 + q] = up_nempty[q];
      end
      iclr = '0;
      if (wr_en) begin
        case (addr)
          5'd4:  m_uo[31:0]  = m_uo[31:0]  & ~wdata;
          5'd5:  m_uo[63:32] = m_uo[63:32] & ~wdata;
          5'd8, 5'd9, 5'd10, 5'd11:
            for (int k = 0; k < 8; k++) m_sel[(addr-8)*8 + k] = wdata[4*k +: 3];
          5'd12: m_ien[31:0]  = wdata;
          5'd13: m_ien[63:32] = wdata;
          5'd14: iclr[31:0]   = wdata;
          5'd15: iclr[63:32]  = wdata;
          5'd16: m_aux = wdata[0];
          default: ;
        endcase
      end
      for (int q = 0; q < 32; q++) begin
        m_uo[2*q]     = m_uo[2*q]     | lo_uflow[q];
        m_uo[2*q + 1] = m_uo[2*q + 1] | lo_oflow[q];
        m_ls[q] = {lo_full[q], lo_nfull[q], lo_nempty[q], lo_empty[q]};
      end
      m_upne = up_nempty;
      m_upf  = up_full;
      m_ist  = (m_ist & ~iclr) | cond;
      m_irq  = |(m_ist & m_ien);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      check(tag_of(m_ra), rdata, m_rd);
      check("R8 irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  // ---------------- stimulus helpers (entered at a negedge) ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  task automatic reset_read(input logic [4:0] a, input logic [31:0] exp);
    rst = 1'b1; addr = a;
    repeat (2) @(negedge clk);
    check("R1 reset rdata", rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset value", rdata, exp);
  endtask

  task automatic zero_flags();
    lo_empty = '0; lo_nempty = '0; lo_nfull = '0; lo_full = '0;
    up_nempty = '0; up_full = '0; lo_uflow = '0; lo_oflow = '0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset values, one reset pulse per word
    reset_read(5'd0,  32'h33333333);
    reset_read(5'd3,  32'h33333333);
    reset_read(5'd4,  32'h00000000);
    reset_read(5'd6,  32'hFFFFFFFF);
    reset_read(5'd7,  32'h00000000);
    reset_read(5'd8,  32'h00000000);
    reset_read(5'd12, 32'h00000000);
    reset_read(5'd14, 32'hFFFFFFFF);
    reset_read(5'd15, 32'hFFFFFFFF);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    cmp_on = 1'b1;

    // R10: unmapped read, write to read-only word
    rd(5'd20, 32'h0, "R10 unmapped");
    wr(5'd0, 32'h12345678);
    rd(5'd0, 32'h0, "R10 ro write ignored");

    // R7/R8: clear everything, enable queue 5, raise its empty flag
    wr(5'd14, '1); wr(5'd15, '1);
    wr(5'd12, 32'h20);
    rd(5'd14, 32'h0, "R7 cleared");
    check("R8 irq idle", {31'd0, irq}, 32'd0);
    lo_empty[5] = 1'b1;
    @(negedge clk);
    check("R8 irq rises one cycle after flag", {31'd0, irq}, 32'd1);
    wr(5'd14, 32'h20);
    rd(5'd14, 32'h20, "R7 set wins over clear");
    lo_empty[5] = 1'b0;
    @(negedge clk);
    wr(5'd14, 32'h20);
    rd(5'd14, 32'h0, "R7 clear");
    check("R8 irq falls", {31'd0, irq}, 32'd0);

    // R5: queue 3 selector = inverted empty (code 4)
    wr(5'd8, 32'h00004000);
    @(negedge clk);
    rd(5'd14, 32'h00000008, "R5 inverted empty");

    // R6: upper queue 40 nearly-empty
    up_nempty[8] = 1'b1;
    @(negedge clk);
    rd(5'd15, 32'h00000100, "R6 fixed source");

    // R4: overflow pulse on queue 17
    lo_oflow[17] = 1'b1;
    @(negedge clk);
    lo_oflow[17] = 1'b0;
    rd(5'd5, 32'h00000008, "R4 overflow bit");
    wr(5'd5, 32'h00000008);
    rd(5'd5, 32'h0, "R4 clear");

    // R2 / R3 placement
    lo_nfull[10] = 1'b1; up_full[31] = 1'b1;
    @(negedge clk);
    rd(5'd1, 32'h00000400, "R2 nibble position");
    rd(5'd7, 32'h80000000, "R3 full position");

    // R9: control bit survives selector word write
    wr(5'd16, 32'h1);
    check("R9 aux set", {31'd0, aux_ctrl}, 32'd1);
    wr(5'd8, 32'hFFFFFFFF);
    check("R9 aux kept", {31'd0, aux_ctrl}, 32'd1);
    rd(5'd8, 32'h7777777F, "R9 selector readback");
    wr(5'd8, 32'h00000000);
    rd(5'd8, 32'h00000008, "R9 aux after clear write");

    // Random traffic against the model
    zero_flags();
    for (int i = 0; i < 4000; i++) begin
      if (i % 8 == 0) begin
        lo_empty = $urandom; lo_nempty = $urandom; lo_nfull = $urandom; lo_full = $urandom;
        up_nempty = $urandom; up_full = $urandom;
      end
      lo_uflow = $urandom & $urandom & $urandom;
      lo_oflow = $urandom & $urandom & $urandom;
      addr  = 5'($urandom % 32);
      wr_en = (($urandom % 4) == 0);
      wdata = $urandom;
      @(negedge clk);
    end
    wr_en = 1'b0;
    zero_flags();
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule